// File: doc/BRIEF.md
# Set-Associative Translation Cache with Page-Number Invalidation

This block caches virtual-to-physical translations for an I/O address translation unit. It holds entries for 4 KiB, 64 KiB and 1 MiB pages in a set-associative array of 64 sets by 8 ways. A lookup presents a virtual address and gets back, in the same cycle, a hit flag, the translated physical address, the page size of the matching entry, and a flag that is set when more than one way matches.

After a page walk, the walker writes the result through the refill port. Software maintenance uses two command words. The flush word clears the whole array. The invalidate word removes matching entries from one set, selected by a 4 KiB-aligned virtual page number. In both words, bit 0 is the request flag.

The set index is always taken from address bits [17:12]. For a refill, those bits come from the access that missed. As a result, a 64 KiB page can hold copies in up to 16 sets, and a 1 MiB page can hold copies in any of the 64 sets. Removing such a page completely therefore needs one invalidate per set that may hold a copy.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every lookup misses, with lk_mhit_o low.
- R2: A lookup hits only an entry in set lk_va_i[17:12] whose tag matches the address. For a 4 KiB entry, all of bits [31:12] are compared, and lk_pa_o = {stored frame, va[11:0]} with lk_size_o = 0. On a miss, lk_pa_o and lk_size_o are 0.
- R3: A 64 KiB entry (size code 1) ignores tag bits [15:12]. It gives lk_pa_o = {frame[31:16], va[15:0]}. A lookup of the same 64 KiB page through a different set index misses.
- R4: A 1 MiB entry (size code 2) ignores tag bits [19:12], so address bits [19:18] may differ from the refill address. It gives lk_pa_o = {frame[31:20], va[19:0]}.
- R5: When two or more ways of the indexed set match, lk_hit_o and lk_mhit_o are both 1, and the lowest matching way supplies the result.
- R6: A flush write with bit 0 = 1 invalidates every entry. A flush write with bit 0 = 0 has no effect.
- R7: An invalidate write with bit 0 = 1 removes, from set word[17:12] only, every way whose size-masked tag matches word[31:12]. Bits [11:1] are ignored. Other sets are untouched.
- R8: An invalidate write with bit 0 = 0 has no effect.
- R9: A refill fills the lowest-numbered invalid way of its set. If the set is full, it replaces the way named by that set's round-robin pointer. The pointer starts at 0 and advances by one only on such a replacement.
- R10: A flush in the same cycle as a refill leaves the array empty.
- R11: A refill becomes visible to lookups from the cycle after its clock edge. Lookup is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_mhit_o | output | 1 | More than one way matched |
| lk_pa_o | output | 32 | Translated physical address |
| lk_size_o | output | 2 | Page size code of the hit (0 = 4K, 1 = 64K, 2 = 1M) |
| rf_we_i | input | 1 | Refill strobe |
| rf_va_i | input | 32 | Refill virtual address (selects set and tag) |
| rf_pa_i | input | 32 | Refill physical frame address |
| rf_size_i | input | 2 | Refill page size code |
| fl_we_i | input | 1 | Flush word write strobe |
| fl_word_i | input | 32 | Flush word; bit 0 requests flush-all |
| inv_we_i | input | 1 | Invalidate word write strobe |
| inv_word_i | input | 32 | Page address in [31:12]; bit 0 requests the invalidate |

## Verification
The bench uses the default parameters: 32-bit addresses, 64 sets and 8 ways. With these values the [17:12] index, the 4-bit and 8-bit tag masks for large pages, and a 3-bit round-robin pointer all come out as specified. A single set can be filled past its 8 ways with a dozen refills, so the bench can walk the pointer through eviction and then through refilling a hole left by an invalidate. Placing a 64 KiB page in two sets, and a 1 MiB page together with an overlapping 4 KiB page, exercises per-set removal and the multi-hit case.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2
  } pg_size_e;

  localparam int PG_SHIFT = 12;  // base page offset bits
  localparam int SH_64K   = 4;   // extra offset bits of a 64K page
  localparam int SH_1M    = 8;   // extra offset bits of a 1M page
endpackage

// File: rtl/tlb_way_cmp.sv
module tlb_way_cmp
  import tlb_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic             vld_i,
  input  logic [VPN_W-1:0] tag_i,
  input  pg_size_e         size_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic             match_o
);
  logic [VPN_W-1:0] mask;

  always_comb begin
    unique case (size_i)
      PG_64K:  mask = ~VPN_W'((1 << SH_64K) - 1);
      PG_1M:   mask = ~VPN_W'((1 << SH_1M) - 1);
      default: mask = '1;
    endcase
  end

  assign match_o = vld_i && (((tag_i ^ vpn_i) & mask) == '0);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS  = 8,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  vld_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             full_o
);
  always_comb begin
    full_o = &vld_i;
    way_o  = rr_i;
    if (!full_o) begin
      for (int i = WAYS - 1; i >= 0; i--) begin
        if (!vld_i[i]) way_o = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int SETS = 64,
  parameter int WAYS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [VA_W-1:0] lk_va_i,
  output logic            lk_hit_o,
  output logic            lk_mhit_o,
  output logic [PA_W-1:0] lk_pa_o,
  output logic [1:0]      lk_size_o,
  input  logic            rf_we_i,
  input  logic [VA_W-1:0] rf_va_i,
  input  logic [PA_W-1:0] rf_pa_i,
  input  logic [1:0]      rf_size_i,
  input  logic            fl_we_i,
  input  logic [VA_W-1:0] fl_word_i,
  input  logic            inv_we_i,
  input  logic [VA_W-1:0] inv_word_i
);
  localparam int VPN_W = VA_W - PG_SHIFT;
  localparam int PPN_W = PA_W - PG_SHIFT;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int OFF_MAX = PG_SHIFT + SH_1M;

  logic [WAYS-1:0]  vld_q  [SETS];
  logic [WAY_W-1:0] rr_q   [SETS];
  logic [VPN_W-1:0] tag_q  [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q  [SETS][WAYS];
  pg_size_e         size_q [SETS][WAYS];

  logic [SET_W-1:0] lk_set, inv_set, rf_set;
  logic [VPN_W-1:0] lk_vpn, inv_vpn;
  logic [WAYS-1:0]  lk_hits, inv_hits;
  logic             fl_fire, inv_fire;
  logic [WAY_W-1:0] rf_way;
  logic             rf_full;

  assign lk_set   = lk_va_i[PG_SHIFT +: SET_W];
  assign lk_vpn   = lk_va_i[VA_W-1:PG_SHIFT];
  assign inv_set  = inv_word_i[PG_SHIFT +: SET_W];
  assign inv_vpn  = inv_word_i[VA_W-1:PG_SHIFT];
  assign rf_set   = rf_va_i[PG_SHIFT +: SET_W];
  assign fl_fire  = fl_we_i && fl_word_i[0];
  assign inv_fire = inv_we_i && inv_word_i[0];

  // one comparator per way for the lookup set and one for the invalidate set
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way_cmp #(.VPN_W(VPN_W)) u_lk_cmp (
      .vld_i   (vld_q[lk_set][w]),
      .tag_i   (tag_q[lk_set][w]),
      .size_i  (size_q[lk_set][w]),
      .vpn_i   (lk_vpn),
      .match_o (lk_hits[w])
    );
    tlb_way_cmp #(.VPN_W(VPN_W)) u_inv_cmp (
      .vld_i   (vld_q[inv_set][w]),
      .tag_i   (tag_q[inv_set][w]),
      .size_i  (size_q[inv_set][w]),
      .vpn_i   (inv_vpn),
      .match_o (inv_hits[w])
    );
  end

  tlb_victim #(.WAYS(WAYS)) u_victim (
    .vld_i  (vld_q[rf_set]),
    .rr_i   (rr_q[rf_set]),
    .way_o  (rf_way),
    .full_o (rf_full)
  );

  // lowest matching way drives the result
  logic [WAY_W-1:0] sel_way;
  always_comb begin
    sel_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_hits[w]) sel_way = WAY_W'(w);
    end
  end

  pg_size_e         sel_size;
  logic [PA_W-1:0]  off_mask, frame, va_low;
  assign sel_size = size_q[lk_set][sel_way];
  assign frame    = {ppn_q[lk_set][sel_way], {PG_SHIFT{1'b0}}};
  assign va_low   = PA_W'(lk_va_i[OFF_MAX-1:0]);

  always_comb begin
    unique case (sel_size)
      PG_64K:  off_mask = PA_W'((1 << (PG_SHIFT + SH_64K)) - 1);
      PG_1M:   off_mask = PA_W'((1 << (PG_SHIFT + SH_1M)) - 1);
      default: off_mask = PA_W'((1 << PG_SHIFT) - 1);
    endcase
  end

  assign lk_hit_o  = |lk_hits;
  assign lk_mhit_o = $countones(lk_hits) > 1;
  assign lk_pa_o   = lk_hit_o ? ((frame & ~off_mask) | (va_low & off_mask)) : '0;
  assign lk_size_o = lk_hit_o ? sel_size : 2'd0;

  // valid bits and replacement pointers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (fl_fire) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (inv_fire) vld_q[inv_set] <= vld_q[inv_set] & ~inv_hits;
      if (rf_we_i) begin
        vld_q[rf_set][rf_way] <= 1'b1;
        if (rf_full) rr_q[rf_set] <= rr_q[rf_set] + 1'b1;
      end
    end
  end

  // entry payload, no reset needed
  always_ff @(posedge clk_i) begin
    if (rf_we_i) begin
      tag_q[rf_set][rf_way]  <= rf_va_i[VA_W-1:PG_SHIFT];
      ppn_q[rf_set][rf_way]  <= rf_pa_i[PA_W-1:PG_SHIFT];
      size_q[rf_set][rf_way] <= pg_size_e'(rf_size_i);
    end
  end

  p_flush_empties_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_fire |=> !lk_hit_o);

  p_refill_visible_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_i && !fl_fire && lk_vpn == rf_va_i[VA_W-1:PG_SHIFT])
      |=> (lk_hit_o || !$stable(lk_va_i)));

  p_inv_removes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_fire && !rf_we_i && lk_vpn == inv_vpn)
      |=> (!lk_hit_o || !$stable(lk_va_i)));

  p_hit_persists_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && !fl_fire && !inv_fire && !rf_we_i)
      |=> (lk_hit_o || !$stable(lk_va_i)));

  p_mhit_needs_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_mhit_o |-> lk_hit_o);
endmodule

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lk_va_i = '0;
  logic        lk_hit_o, lk_mhit_o;
  logic [31:0] lk_pa_o;
  logic [1:0]  lk_size_o;
  logic        rf_we_i = 1'b0;
  logic [31:0] rf_va_i = '0, rf_pa_i = '0;
  logic [1:0]  rf_size_i = '0;
  logic        fl_we_i = 1'b0;
  logic [31:0] fl_word_i = '0;
  logic        inv_we_i = 1'b0;
  logic [31:0] inv_word_i = '0;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  tlb_xlate u_tlb_xlate (.*);

  // {va, hit, pa, size}
  localparam logic [66:0] VEC [8] = '{
    {32'h1000_5ABC, 1'b1, 32'h8765_4ABC, 2'd0},
    {32'h1000_6ABC, 1'b0, 32'h0000_0000, 2'd0},
    {32'h1001_5ABC, 1'b0, 32'h0000_0000, 2'd0},
    {32'h2001_7F0F, 1'b1, 32'h4433_7F0F, 2'd1},
    {32'h2001_8000, 1'b0, 32'h0000_0000, 2'd0},
    {32'h305C_3123, 1'b1, 32'h770C_3123, 2'd2},
    {32'h3050_3000, 1'b1, 32'h7700_3000, 2'd2},
    {32'h3051_3000, 1'b0, 32'h0000_0000, 2'd0}
  };
  localparam string VEC_REQ [8] = '{"R2", "R2", "R2", "R3", "R3", "R4", "R4", "R4"};

  task automatic chk(input logic [31:0] va, input bit eh, input bit em,
                     input logic [31:0] epa, input logic [1:0] esz,
                     input bit cpa, input string req);
    lk_va_i = va;
    #1;
    tests++;
    if (lk_hit_o !== eh || lk_mhit_o !== em ||
        (cpa && (lk_pa_o !== epa || lk_size_o !== esz))) begin
      fails++;
      $display("FAIL %s va=%h: hit=%0b mhit=%0b pa=%h sz=%0d, expected hit=%0b mhit=%0b pa=%h sz=%0d",
               req, va, lk_hit_o, lk_mhit_o, lk_pa_o, lk_size_o, eh, em, epa, esz);
    end
  endtask

  task automatic refill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    @(negedge clk_i);
    rf_we_i = 1'b1; rf_va_i = va; rf_pa_i = pa; rf_size_i = sz;
    @(negedge clk_i);
    rf_we_i = 1'b0;
  endtask

  task automatic inval(input logic [31:0] w);
    @(negedge clk_i);
    inv_we_i = 1'b1; inv_word_i = w;
    @(negedge clk_i);
    inv_we_i = 1'b0;
  endtask

  task automatic flush(input logic [31:0] w);
    @(negedge clk_i);
    fl_we_i = 1'b1; fl_word_i = w;
    @(negedge clk_i);
    fl_we_i = 1'b0;
  endtask

  function automatic logic [31:0] rva(input int k);
    return (32'(k) << 20) | 32'h0002_A000;
  endfunction
  function automatic logic [31:0] rpa(input int k);
    return 32'h9000_0000 | (32'(k) << 12);
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk(32'h1000_5000, 0, 0, 0, 0, 1, "R1");
    chk(32'h0000_0000, 0, 0, 0, 0, 1, "R1");

    // R11: refill not visible before its edge, visible after
    @(negedge clk_i);
    rf_we_i = 1'b1; rf_va_i = 32'h1000_5000; rf_pa_i = 32'h8765_4000; rf_size_i = 2'd0;
    chk(32'h1000_5000, 0, 0, 0, 0, 1, "R11");
    @(negedge clk_i);
    rf_we_i = 1'b0;
    chk(32'h1000_5000, 1, 0, 32'h8765_4000, 0, 1, "R11");

    refill(32'h2001_7000, 32'h4433_0000, 2'd1);
    refill(32'h3050_3000, 32'h7700_0000, 2'd2);
    for (int i = 0; i < 8; i++)
      chk(VEC[i][66:35], VEC[i][34], 0, VEC[i][33:2], VEC[i][1:0], 1, VEC_REQ[i]);

    // R5: 4K page overlapping the 1M page in set 3
    refill(32'h3050_3000, 32'h1111_1000, 2'd0);
    chk(32'h3050_3004, 1, 1, 32'h7700_3004, 2'd2, 1, "R5");

    // R7: 1M removed by masked match, 4K (full tag differs) survives
    inval(32'h305C_3001);
    chk(32'h3050_3004, 1, 0, 32'h1111_1004, 2'd0, 1, "R7");
    inval(32'h3050_3FF1);
    chk(32'h3050_3004, 0, 0, 0, 0, 1, "R7");

    // R8 / R6: requests without bit 0 do nothing
    inval(32'h1000_5000);
    chk(32'h1000_5ABC, 1, 0, 32'h8765_4ABC, 0, 1, "R8");
    flush(32'hFFFF_FFFE);
    chk(32'h1000_5ABC, 1, 0, 32'h8765_4ABC, 0, 1, "R6");

    // R7 / R3: 64K page held in two sets, removed per set
    refill(32'h2001_8000, 32'h4433_0000, 2'd1);
    chk(32'h2001_8000, 1, 0, 32'h4433_8000, 2'd1, 1, "R3");
    inval(32'h2001_7001);
    chk(32'h2001_7000, 0, 0, 0, 0, 1, "R7");
    chk(32'h2001_8000, 1, 0, 32'h4433_8000, 2'd1, 1, "R7");

    // R9 replacement in set 0x2A
    for (int k = 0; k < 8; k++) refill(rva(k), rpa(k), 2'd0);
    for (int k = 0; k < 8; k++) chk(rva(k), 1, 0, rpa(k), 0, 1, "R9");
    refill(rva(8), rpa(8), 2'd0);
    chk(rva(0), 0, 0, 0, 0, 1, "R9");
    chk(rva(1), 1, 0, rpa(1), 0, 1, "R9");
    chk(rva(8), 1, 0, rpa(8), 0, 1, "R9");
    refill(rva(9), rpa(9), 2'd0);
    chk(rva(1), 0, 0, 0, 0, 1, "R9");
    chk(rva(2), 1, 0, rpa(2), 0, 1, "R9");
    inval(rva(5) | 32'h1);
    chk(rva(5), 0, 0, 0, 0, 1, "R9");
    refill(rva(10), rpa(10), 2'd0);  // fills the hole, pointer stays at 2
    refill(rva(11), rpa(11), 2'd0);  // evicts way 2
    chk(rva(2), 0, 0, 0, 0, 1, "R9");
    chk(rva(3), 1, 0, rpa(3), 0, 1, "R9");
    chk(rva(10), 1, 0, rpa(10), 0, 1, "R9");
    chk(rva(11), 1, 0, rpa(11), 0, 1, "R9");

    // R10: flush wins over a refill in the same cycle
    @(negedge clk_i);
    fl_we_i = 1'b1; fl_word_i = 32'h1;
    rf_we_i = 1'b1; rf_va_i = 32'h4000_1000; rf_pa_i = 32'h5000_0000; rf_size_i = 2'd0;
    @(negedge clk_i);
    fl_we_i = 1'b0; rf_we_i = 1'b0;
    chk(32'h4000_1000, 0, 0, 0, 0, 1, "R10");
    chk(32'h1000_5ABC, 0, 0, 0, 0, 1, "R6");
    chk(32'h2001_8000, 0, 0, 0, 0, 1, "R6");
    chk(rva(3), 0, 0, 0, 0, 1, "R6");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule